// File: doc/BRIEF.md
# Dual-Mode Byte-Wide Parallel Port

This block connects one set of eight bidirectional data pads to two possible owners. In memory-interface mode the external memory controller owns the pads completely. Its low data byte is copied to the pads, it decides the pad direction, and the pad inputs are returned to it. In link mode an internal DMA channel moves bytes across the pads one at a time. Each byte uses a four-phase request/acknowledge handshake with the external device. Software fixes the direction of the link through a register bit.

Three single-bit control registers hold the configuration. A mode bit picks the owner. A direction bit picks input or output for the link. A redirect bit, in link mode, hands the pads to the memory controller whenever it accesses bank 2. This lets one peripheral be reached both through register accesses and through DMA. The request wire is brought into the clock domain by a two-flop synchronizer. A byte-level state machine then sequences each transfer.

The link state machine has four states. LK_IDLE waits for a request. LK_ACK holds the acknowledge high. LK_TURN is a one-cycle turnaround with the pad drivers off, and it is where a new direction is taken over. LK_MEM is entered while memory-interface mode is selected. Its transitions are:
- idle-to-ack: a synchronized request arrives, a byte can be moved, and no bank-2 redirect access is active.
- ack-to-idle: the synchronized request falls.
- idle-to-turn: the requested direction differs from the active one.
- turn-to-idle: after one clock.
- any-to-mem: the mode bit becomes 1.
- mem-to-turn: the mode bit returns to 0.

Top module: `bpp_port`

## Requirements
- R1: After reset all three control bits read 0, the link is in input direction, pad_oe is 0, ack_out is 0, tx_ready is 0 and rx_valid is 0.
- R2: Register bit 0 at byte offset 0 is redirect-enable, at offset 4 is link direction (0 = input, 1 = output), and at offset 8 is mode (0 = link, 1 = memory-interface). Reads return the bit in bit 0 with the upper bits 0. Any other offset reads 0, and a write to it changes no register.
- R3: With mode = 1, pad_out equals mem_wdata, pad_oe equals mem_oe, mem_rdata equals pad_in and mem_grant is 1.
- R4: With mode = 1, ack_out stays 0 whatever ext_req does.
- R5: With mode = 0, redirect = 1, mem_bank2 = 1 and no handshake in progress, the pads follow the memory controller (mem_grant = 1) and no new handshake starts. With redirect = 0, mem_bank2 has no effect.
- R6: In output direction, tx_ready is 1 only when no byte is pending. An accepted byte is driven on pad_out with pad_oe = 1 and is released when the handshake completes.
- R7: In input direction, with the receive register empty, a rising synchronized request captures pad_in into rx_data. ack_out rises and stays 1 until the request returns low.
- R8: A captured byte is held in rx_data, with rx_valid = 1, until rx_ready is seen. No new acknowledge is given before then.
- R9: ext_req passes through two flops. Driven high between clock edges, it raises ack_out on the third following rising edge and not before.
- R10: A direction write during a handshake takes effect only after the handshake ends. Between driving in one direction and the other, the link keeps pad_oe low for at least one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | AW | Register byte offset |
| reg_wbit | input | 1 | Write data bit 0 |
| reg_rdata | output | RW | Read data |
| mem_wdata | input | DW | Low byte of memory controller data out |
| mem_oe | input | 1 | Memory controller pad drive enable |
| mem_bank2 | input | 1 | Memory controller is accessing bank 2 |
| mem_rdata | output | DW | Pad input returned to memory controller |
| mem_grant | output | 1 | Pads currently owned by memory controller |
| tx_data | input | DW | DMA byte to send |
| tx_valid | input | 1 | DMA send byte valid |
| tx_ready | output | 1 | Port can take a send byte |
| rx_data | output | DW | Received byte |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | DMA takes the received byte |
| pad_out | output | DW | Pad output data |
| pad_oe | output | 1 | Pad output enable |
| pad_in | input | DW | Pad input data |
| ext_req | input | 1 | Asynchronous request from device |
| ack_out | output | 1 | Acknowledge to device |

## Verification
The link is driven with a mixed run of bytes in both directions, including 00, FF, A5, 5A, 01 and 80. All-zero and all-one values show that no pad bit is stuck, and the alternating and single-bit values show that no bits are swapped. Each change of direction inside the run also exercises the turnaround. Directed cases then run the request latency, a receive byte left unread while a new request waits, a direction write in the middle of a handshake, and the ownership of the pads under the redirect bit and under memory-interface mode. These cases tell apart a design that merely moves data from one that also sequences its pad ownership correctly.

// File: rtl/bpp_pkg.sv
package bpp_pkg;

    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_ACK  = 2'd1,
        LK_TURN = 2'd2,
        LK_MEM  = 2'd3
    } link_state_e;

    localparam int unsigned OFS_REDIR = 0;
    localparam int unsigned OFS_DIR   = 4;
    localparam int unsigned OFS_MODE  = 8;

endpackage

// File: rtl/bpp_regs.sv
module bpp_regs
    import bpp_pkg::*;
#(
    parameter int AW = 4,
    parameter int RW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_en,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wbit,
    output logic [RW-1:0] reg_rdata,
    output logic          redir_q,
    output logic          dir_q,
    output logic          mode_q
);

    localparam logic [AW-1:0] A_REDIR = AW'(OFS_REDIR);
    localparam logic [AW-1:0] A_DIR   = AW'(OFS_DIR);
    localparam logic [AW-1:0] A_MODE  = AW'(OFS_MODE);

    logic wr_go;
    assign wr_go = reg_en && reg_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redir_q <= 1'b0;
            dir_q   <= 1'b0;
            mode_q  <= 1'b0;
        end else if (wr_go) begin
            if (reg_addr == A_REDIR) redir_q <= reg_wbit;
            if (reg_addr == A_DIR)   dir_q   <= reg_wbit;
            if (reg_addr == A_MODE)  mode_q  <= reg_wbit;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_en && !reg_we) begin
            unique case (reg_addr)
                A_REDIR: reg_rdata[0] = redir_q;
                A_DIR:   reg_rdata[0] = dir_q;
                A_MODE:  reg_rdata[0] = mode_q;
                default: reg_rdata    = '0;
            endcase
        end
    end

    // R2: without a write strobe the control bits never move
    p_reg_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_go |=> $stable({redir_q, dir_q, mode_q}));

endmodule

// File: rtl/bpp_sync.sv
module bpp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);

    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= d_async;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/bpp_link.sv
module bpp_link
    import bpp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_s,
    input  logic          mode_mem,
    input  logic          redir_hit,
    input  logic          dir_req,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_valid,
    output logic          tx_ready,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    input  logic          rx_ready,
    input  logic [DW-1:0] pad_in,
    output logic [DW-1:0] link_out,
    output logic          link_oe,
    output logic          ack,
    output logic          busy
);

    link_state_e state_q, state_d;
    logic        dir_act;
    logic        tx_pend;
    logic [DW-1:0] tx_buf;
    logic        can_move;
    logic        start_xfer;
    logic        end_xfer;

    assign can_move   = dir_act ? tx_pend : !rx_valid;
    assign start_xfer = (state_q == LK_IDLE) && (state_d == LK_ACK);
    assign end_xfer   = (state_q == LK_ACK) && (state_d == LK_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_IDLE: begin
                if (mode_mem)                                 state_d = LK_MEM;
                else if (dir_req != dir_act)                  state_d = LK_TURN;
                else if (!redir_hit && req_s && can_move)     state_d = LK_ACK;
            end
            LK_ACK: begin
                if (mode_mem)    state_d = LK_MEM;
                else if (!req_s) state_d = LK_IDLE;
            end
            LK_TURN: begin
                if (mode_mem) state_d = LK_MEM;
                else          state_d = LK_IDLE;
            end
            LK_MEM: begin
                if (!mode_mem) state_d = LK_TURN;
            end
            default: state_d = LK_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ack      = 1'b0;
        link_oe  = 1'b0;
        busy     = 1'b0;
        unique case (state_q)
            LK_IDLE: link_oe = dir_act;
            LK_ACK: begin
                ack     = 1'b1;
                busy    = 1'b1;
                link_oe = dir_act;
            end
            LK_TURN: link_oe = 1'b0;
            LK_MEM:  link_oe = 1'b0;
            default: link_oe = 1'b0;
        endcase
        tx_ready = dir_act && dir_req && !mode_mem && !tx_pend;
    end

    assign link_out = tx_buf;

    // active direction only changes in the turnaround state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  dir_act <= 1'b0;
        else if (state_q == LK_TURN) dir_act <= dir_req;
    end

    // send holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_pend <= 1'b0;
            tx_buf  <= '0;
        end else if (tx_valid && tx_ready) begin
            tx_pend <= 1'b1;
            tx_buf  <= tx_data;
        end else if (end_xfer && dir_act) begin
            tx_pend <= 1'b0;
        end
    end

    // receive holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else if (start_xfer && !dir_act) begin
            rx_valid <= 1'b1;
            rx_data  <= pad_in;
        end else if (rx_valid && rx_ready) begin
            rx_valid <= 1'b0;
        end
    end

    // R10: a change of active direction follows a cycle with drivers off
    p_turn_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_act != $past(dir_act)) |-> !$past(link_oe));

    // R10: direction is frozen while the acknowledge is up
    p_dir_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(ack)) |-> $stable(dir_act));

    // R8: an unread byte is neither lost nor overwritten
    p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    // R6: ready only with an empty send register
    p_tx_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !tx_pend);

    // R7: acknowledge only rises on a synchronized request
    p_ack_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(req_s));

endmodule

// File: rtl/bpp_pad_mux.sv
module bpp_pad_mux #(
    parameter int DW = 8
) (
    input  logic          mode_mem,
    input  logic          redir_on,
    input  logic          mem_bank2,
    input  logic          link_busy,
    input  logic [DW-1:0] mem_wdata,
    input  logic          mem_oe,
    input  logic [DW-1:0] link_out,
    input  logic          link_oe,
    input  logic [DW-1:0] pad_in,
    output logic [DW-1:0] pad_out,
    output logic          pad_oe,
    output logic [DW-1:0] mem_rdata,
    output logic          mem_grant
);

    logic mem_own;

    assign mem_own   = mode_mem || (redir_on && mem_bank2 && !link_busy);
    assign mem_grant = mem_own;
    assign pad_out   = mem_own ? mem_wdata : link_out;
    assign pad_oe    = mem_own ? mem_oe    : link_oe;
    assign mem_rdata = pad_in;

endmodule

// File: rtl/bpp_port.sv
module bpp_port
    import bpp_pkg::*;
#(
    parameter int DW          = 8,
    parameter int AW          = 4,
    parameter int RW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_en,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wbit,
    output logic [RW-1:0] reg_rdata,
    input  logic [DW-1:0] mem_wdata,
    input  logic          mem_oe,
    input  logic          mem_bank2,
    output logic [DW-1:0] mem_rdata,
    output logic          mem_grant,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_valid,
    output logic          tx_ready,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    input  logic          rx_ready,
    output logic [DW-1:0] pad_out,
    output logic          pad_oe,
    input  logic [DW-1:0] pad_in,
    input  logic          ext_req,
    output logic          ack_out
);

    logic          redir_q, dir_q, mode_q;
    logic          req_s;
    logic [DW-1:0] link_out;
    logic          link_oe;
    logic          link_busy;

    bpp_regs #(.AW(AW), .RW(RW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_en   (reg_en),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wbit (reg_wbit),
        .reg_rdata(reg_rdata),
        .redir_q  (redir_q),
        .dir_q    (dir_q),
        .mode_q   (mode_q)
    );

    bpp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(ext_req),
        .d_sync (req_s)
    );

    bpp_link #(.DW(DW)) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_s    (req_s),
        .mode_mem (mode_q),
        .redir_hit(redir_q && mem_bank2),
        .dir_req  (dir_q),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_ready (rx_ready),
        .pad_in   (pad_in),
        .link_out (link_out),
        .link_oe  (link_oe),
        .ack      (ack_out),
        .busy     (link_busy)
    );

    bpp_pad_mux #(.DW(DW)) u_mux (
        .mode_mem (mode_q),
        .redir_on (redir_q),
        .mem_bank2(mem_bank2),
        .link_busy(link_busy),
        .mem_wdata(mem_wdata),
        .mem_oe   (mem_oe),
        .link_out (link_out),
        .link_oe  (link_oe),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .mem_rdata(mem_rdata),
        .mem_grant(mem_grant)
    );

    // R4: a settled memory-interface mode keeps the acknowledge inactive
    p_ack_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && $past(mode_q)) |-> !ack_out);

    // R3: memory-interface mode hands the pads to the memory controller
    p_mem_own_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> mem_grant);

endmodule

// File: tb/sim_bpp_port.sv
module sim_bpp_port;

    localparam int DW = 8;
    localparam int AW = 4;
    localparam int RW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_en = 1'b0, reg_we = 1'b0, reg_wbit = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [RW-1:0] reg_rdata;
    logic [DW-1:0] mem_wdata = '0, mem_rdata;
    logic          mem_oe = 1'b0, mem_bank2 = 1'b0, mem_grant;
    logic [DW-1:0] tx_data = '0, rx_data;
    logic          tx_valid = 1'b0, tx_ready, rx_valid, rx_ready = 1'b0;
    logic [DW-1:0] pad_out, pad_in = '0;
    logic          pad_oe, ext_req = 1'b0, ack_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    bpp_port #(.DW(DW), .AW(AW), .RW(RW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wbit(reg_wbit), .reg_rdata(reg_rdata),
        .mem_wdata(mem_wdata), .mem_oe(mem_oe), .mem_bank2(mem_bank2),
        .mem_rdata(mem_rdata), .mem_grant(mem_grant),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in),
        .ext_req(ext_req), .ack_out(ack_out)
    );

    // bit 8 = direction (1 = output), bits 7:0 = byte
    localparam logic [8:0] VEC [0:7] = '{
        9'h000, 9'h0FF, 9'h1A5, 9'h15A, 9'h101, 9'h080, 9'h07E, 9'h1C3
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [AW-1:0] a, input logic b);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wbit = b;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [AW-1:0] a, output logic [RW-1:0] v);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_en = 1'b0;
    endtask

    task automatic wait_ack(input logic lvl);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (ack_out == lvl) break;
        end
    endtask

    task automatic set_dir(input logic d);
        reg_write(4'd4, d);
        repeat (3) @(negedge clk);
    endtask

    task automatic rx_take;
        @(negedge clk); rx_ready = 1'b1;
        @(negedge clk); rx_ready = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [RW-1:0] rv;
        logic          cur_dir;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pad_oe", pad_oe, 0);
        chk("R1 ack_out", ack_out, 0);
        chk("R1 tx_ready", tx_ready, 0);
        chk("R1 rx_valid", rx_valid, 0);
        reg_read(4'd0, rv); chk("R1 redirect", rv, 0);
        reg_read(4'd4, rv); chk("R1 direction", rv, 0);
        reg_read(4'd8, rv); chk("R1 mode", rv, 0);

        // R2 map, readback, unmapped offset
        reg_write(4'd0, 1'b1);
        reg_read(4'd0, rv); chk("R2 redirect readback", rv, 1);
        reg_read(4'd4, rv); chk("R2 direction untouched", rv, 0);
        reg_write(4'd0, 1'b0);
        reg_write(4'd12, 1'b1);
        reg_read(4'd12, rv); chk("R2 unmapped reads 0", rv, 0);
        reg_read(4'd0, rv);  chk("R2 unmapped write ignored 0", rv, 0);
        reg_read(4'd4, rv);  chk("R2 unmapped write ignored 4", rv, 0);
        reg_read(4'd8, rv);  chk("R2 unmapped write ignored 8", rv, 0);

        // R9 synchronizer latency (input direction, receive empty)
        pad_in = 8'h3E;
        @(negedge clk); ext_req = 1'b1;
        @(negedge clk); chk("R9 no ack after 1 edge", ack_out, 0);
        @(negedge clk); chk("R9 no ack after 2 edges", ack_out, 0);
        @(negedge clk); chk("R9 ack after 3 edges", ack_out, 1);
        ext_req = 1'b0;
        wait_ack(1'b0);
        chk("R7 captured", rx_data, 8'h3E);
        rx_take();

        // vector table walked in one loop: R6 / R7
        cur_dir = 1'b0;
        for (int i = 0; i < 8; i++) begin
            logic       d;
            logic [7:0] b;
            d = VEC[i][8];
            b = VEC[i][7:0];
            if (d != cur_dir) begin
                set_dir(d);
                cur_dir = d;
            end
            if (d) begin
                @(negedge clk); tx_valid = 1'b1; tx_data = b;
                for (int k = 0; k < 20; k++) begin
                    if (tx_ready) begin
                        @(negedge clk);
                        break;
                    end
                    @(negedge clk);
                end
                tx_valid = 1'b0;
                chk("R6 ready low while pending", tx_ready, 0);
                ext_req = 1'b1;
                wait_ack(1'b1);
                chk("R6 pad_out byte", {pad_oe, pad_out}, {1'b1, b});
                ext_req = 1'b0;
                wait_ack(1'b0);
                chk("R6 ready after release", tx_ready, 1);
            end else begin
                pad_in = b;
                @(negedge clk); ext_req = 1'b1;
                wait_ack(1'b1);
                chk("R7 ack high, pads not driven", {ack_out, pad_oe}, 2'b10);
                ext_req = 1'b0;
                wait_ack(1'b0);
                chk("R7 received byte", {rx_valid, rx_data}, {1'b1, b});
                rx_take();
            end
        end
        set_dir(1'b0);

        // R8 unread byte blocks the next acknowledge
        pad_in = 8'h11;
        @(negedge clk); ext_req = 1'b1;
        wait_ack(1'b1);
        ext_req = 1'b0;
        wait_ack(1'b0);
        pad_in = 8'h22;
        @(negedge clk); ext_req = 1'b1;
        repeat (8) @(negedge clk);
        chk("R8 no ack while unread", ack_out, 0);
        chk("R8 byte held", {rx_valid, rx_data}, {1'b1, 8'h11});
        rx_take();
        wait_ack(1'b1);
        chk("R8 next byte after read", rx_data, 8'h22);
        ext_req = 1'b0;
        wait_ack(1'b0);
        rx_take();

        // R10 direction write in the middle of a handshake
        pad_in = 8'h33;
        @(negedge clk); ext_req = 1'b1;
        wait_ack(1'b1);
        reg_write(4'd4, 1'b1);
        repeat (3) @(negedge clk);
        chk("R10 ack kept during handshake", ack_out, 1);
        chk("R10 no drive before handshake ends", pad_oe, 0);
        ext_req = 1'b0;
        wait_ack(1'b0);
        @(negedge clk); chk("R10 turnaround oe low", pad_oe, 0);
        @(negedge clk); chk("R10 output drive after turn", pad_oe, 1);
        rx_take();
        // output to input: driving, then a low cycle
        reg_write(4'd4, 1'b0);
        chk("R10 still driving one cycle", pad_oe, 1);
        @(negedge clk); chk("R10 oe low on turn to input", pad_oe, 0);
        repeat (2) @(negedge clk);

        // R5 redirect of bank 2
        reg_write(4'd0, 1'b1);
        mem_wdata = 8'h3C; mem_oe = 1'b1; mem_bank2 = 1'b1;
        @(negedge clk);
        chk("R5 bank2 grants pads", {mem_grant, pad_oe, pad_out}, {2'b11, 8'h3C});
        ext_req = 1'b1;
        repeat (6) @(negedge clk);
        chk("R5 no handshake during redirect", ack_out, 0);
        mem_bank2 = 1'b0;
        wait_ack(1'b1);
        chk("R5 handshake after bank2 drops", ack_out, 1);
        ext_req = 1'b0;
        wait_ack(1'b0);
        rx_take();
        reg_write(4'd0, 1'b0);
        mem_bank2 = 1'b1;
        @(negedge clk);
        chk("R5 bank2 ignored without redirect", {mem_grant, pad_oe}, 2'b00);
        mem_bank2 = 1'b0;

        // R3 / R4 memory-interface mode
        reg_write(4'd8, 1'b1);
        mem_wdata = 8'hC5; mem_oe = 1'b1; pad_in = 8'h5A;
        @(negedge clk);
        chk("R3 pads copy memory byte", {mem_grant, pad_oe, pad_out}, {2'b11, 8'hC5});
        chk("R3 memory sees pads", mem_rdata, 8'h5A);
        mem_oe = 1'b0;
        @(negedge clk);
        chk("R3 memory controls direction", pad_oe, 0);
        ext_req = 1'b1;
        repeat (6) @(negedge clk);
        chk("R4 ack inactive in memory mode", ack_out, 0);
        ext_req = 1'b0;
        repeat (3) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule